// File: doc/BRIEF.md
# Serial EEPROM Transaction Sequencer

This block runs the byte-level slave protocol of a two-wire serial EEPROM holding 1024 bytes in a main array, plus a separate 32-byte space for protection settings and identification data. A bit-level front end hands it START and STOP events and each received byte. The sequencer answers every received byte with an acknowledge decision one clock later. When the master is reading, it returns a data byte one clock after the front end asks for one.

It decodes the device address byte and keeps a 10-bit main pointer and a 5-bit pointer for the protection/ID space. Write data is collected in a 16-byte page latch. Nothing is programmed until STOP. After STOP a self-timed write cycle of `WR_CYCLES` clocks copies the latched bytes into the storage, and the device stays silent while that cycle runs. An external permission checker sees each access as a request with space, address and direction, and returns allow or deny in the same cycle. Both storage arrays are plain synchronous memories with one write port and one registered read port.

Top module: `eeprom_i2c_seq`

## Requirements
- R1: A device byte whose bits 7:3 equal 10101b selects the main array, and B8h or B9h selects the protection/ID space; bit 0 set means read. Any other device byte is NACKed, and every byte after it is NACKed until the next START. The acknowledge for each received byte appears on `ack_valid`/`ack_ok` one cycle after `rx_valid`.
- R2: For a main-array write, the pointer is built as {device byte bits 2:1, word byte}. Only its low 4 bits advance after each data byte, so a write wraps inside its 16-byte page.
- R3: A 17th data byte in one write transfer is NACKed, as is every byte after it. The whole transfer is then dropped and no write cycle starts.
- R4: Programming starts only on STOP. `busy` rises the cycle after STOP and stays high for exactly `WR_CYCLES` cycles. While `busy` is high, every received byte, including a device address, is NACKed.
- R5: Each read returns its byte on `tx_byte` with `tx_valid` one cycle after `tx_req`. Only the low 7 pointer bits advance, so sequential reads wrap from the end of a 128-byte block back to its start.
- R6: On a read command the block bits (device byte bits 2:1) are ignored. The read uses the block latched by the last write command.
- R7: With `wp` high, the device byte and the word address of a write are ACKed and the pointer is set, but every data byte is NACKed and nothing is programmed.
- R8: In the protection/ID space, the pointer is bits 4:0 of the word byte, and a word byte with any of bits 7:5 set is NACKed. Reads return the byte at the pointer.
- R9: A transfer into the protection/ID space carries one data byte only. A second data byte is NACKed and the whole transfer is dropped.
- R10: `perm_req` is raised for every write data byte and for every read device byte. If `perm_ok` is low, that byte is NACKed, and a denied write is dropped.
- R11: While `prot_n` is low, the sequencer returns to idle, gives no acknowledge and discards any partly collected write.
- R12: After reset, `busy`, `ack_valid`, `tx_valid` and `perm_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| prot_n | input | 1 | Active-low protect reset; low holds the sequencer idle |
| wp | input | 1 | Write protect; high refuses all data bytes of writes |
| start_evt | input | 1 | START or repeated START seen by the front end |
| stop_evt | input | 1 | STOP seen by the front end |
| rx_valid | input | 1 | One received byte is on `rx_byte` |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Front end needs the next read byte |
| ack_valid | output | 1 | Acknowledge decision present |
| ack_ok | output | 1 | 1 = ACK, 0 = NACK |
| tx_valid | output | 1 | `tx_byte` holds a read byte |
| tx_byte | output | 8 | Read data |
| perm_req | output | 1 | Permission query for the current byte |
| perm_write | output | 1 | Query is for a write (1) or a read (0) |
| perm_space | output | 1 | Query targets the protection/ID space |
| perm_addr | output | 10 | Address being queried |
| perm_ok | input | 1 | Checker allows the access |
| busy | output | 1 | Self-timed write cycle in progress |

## Verification
The bench builds the block with its default geometry (1024 bytes, 16-byte pages, 128-byte blocks) and with `WR_CYCLES` cut to 40. The short timer lets every one of the 64 pages be programmed with a full 16-byte page write. Each of the 8 blocks is then read back sequentially past its end, which covers every address and every block wrap. The exact length of the busy window is also checked.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_DEV,
    S_WADDR,
    S_WDATA,
    S_RDATA,
    S_IGN
  } seq_st_e;
endpackage

// File: rtl/seq_ram.sv
module seq_ram #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/seq_wlatch.sv
module seq_wlatch #(
  parameter int IDX_W = 4,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [DW-1:0]    rdata,
  output logic             rvalid
);
  localparam int SLOTS = 1 << IDX_W;
  logic [DW-1:0]    slot_q [SLOTS];
  logic [SLOTS-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst || clr) mask_q <= '0;
    else if (we)    mask_q[widx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (we) slot_q[widx] <= wdata;
  end

  assign rdata  = slot_q[ridx];
  assign rvalid = mask_q[ridx];

  // R3: the top never fills and clears the latch in the same cycle
  assert_latch_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(clr && we));
endmodule

// File: rtl/seq_wtimer.sv
module seq_wtimer #(
  parameter int CYC   = 1250000,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  output logic             busy,
  output logic             cen,
  output logic [IDX_W-1:0] cidx,
  output logic             done
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] el;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      el   <= '0;
    end else if (go) begin
      busy <= 1'b1;
      el   <= '0;
    end else if (busy) begin
      if (el == CW'(CYC - 1)) busy <= 1'b0;
      el <= el + 1'b1;
    end
  end

  assign done = busy && (el == CW'(CYC - 1));
  assign cen  = busy && (el < CW'(1 << IDX_W));
  assign cidx = el[IDX_W-1:0];

  // R4: a write cycle is only launched from idle
  assert_go_idle_R4: assert property (@(posedge clk) disable iff (rst)
    go |-> !busy);
  // R4: once running, the cycle is not cut short
  assert_busy_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);
endmodule

// File: rtl/eeprom_i2c_seq.sv
module eeprom_i2c_seq
  import seq_pkg::*;
#(
  parameter int         DEV_BLK_W = 2,
  parameter int         PAGE_W    = 4,
  parameter int         BLK_W     = 7,
  parameter int         PSP_W     = 5,
  parameter int         WR_CYCLES = 1250000,
  parameter logic [7:0] MAIN_CODE = 8'hA8,
  parameter logic [7:0] PROT_CODE = 8'hB8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    prot_n,
  input  logic                    wp,
  input  logic                    start_evt,
  input  logic                    stop_evt,
  input  logic                    rx_valid,
  input  logic [7:0]              rx_byte,
  input  logic                    tx_req,
  output logic                    ack_valid,
  output logic                    ack_ok,
  output logic                    tx_valid,
  output logic [7:0]              tx_byte,
  output logic                    perm_req,
  output logic                    perm_write,
  output logic                    perm_space,
  output logic [DEV_BLK_W+7:0]    perm_addr,
  input  logic                    perm_ok,
  output logic                    busy
);
  localparam int ADDR_W     = DEV_BLK_W + 8;
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int PG_IDX_W   = ADDR_W - PAGE_W;
  localparam int PHI_W      = PSP_W - PAGE_W;
  localparam int CNT_W      = PAGE_W + 1;
  localparam logic [7:0] MAIN_MASK = 8'((1 << (DEV_BLK_W + 1)) - 1);
  localparam logic [CNT_W-1:0] LIM_MAIN = CNT_W'(PAGE_BYTES);
  localparam logic [CNT_W-1:0] LIM_PROT = CNT_W'(1);

  seq_st_e               st;
  logic [ADDR_W-1:0]     mptr;
  logic [PSP_W-1:0]      pptr;
  logic [DEV_BLK_W-1:0]  dblk;
  logic                  spc, tx_sel, abort;
  logic [CNT_W-1:0]      cnt;
  logic                  cm_space;
  logic [PG_IDX_W-1:0]   cm_base;

  logic hit_main, hit_prot, evt_free, byte_take, take, go, clr, rd_go;
  logic cen, done, lvalid;
  logic [PAGE_W-1:0] cidx, widx;
  logic [7:0] ldata, mq, pq;

  assign hit_main = (rx_byte & ~MAIN_MASK) == MAIN_CODE;
  assign hit_prot = (rx_byte & 8'hFE) == PROT_CODE;
  assign evt_free = prot_n && !start_evt && !stop_evt;

  // permission query, answered combinationally by the external checker
  assign perm_req   = rx_valid && evt_free && !busy &&
                      ((st == S_WDATA) ||
                       (st == S_DEV && rx_byte[0] && (hit_main || hit_prot)));
  assign perm_write = (st == S_WDATA);
  assign perm_space = (st == S_DEV) ? hit_prot : spc;
  assign perm_addr  = perm_space ? ADDR_W'(pptr) : mptr;

  assign byte_take = !wp && perm_ok && !abort &&
                     (cnt < (spc ? LIM_PROT : LIM_MAIN));
  assign take  = rx_valid && evt_free && (st == S_WDATA) && byte_take;
  assign go    = stop_evt && prot_n && !start_evt && (st == S_WDATA) &&
                 (cnt != '0) && !abort && !busy;
  assign clr   = done || (!busy && (!prot_n || start_evt || (stop_evt && !go)));
  assign rd_go = tx_req && prot_n && (st == S_RDATA);
  assign widx  = spc ? pptr[PAGE_W-1:0] : mptr[PAGE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || !prot_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      abort     <= 1'b0;
      ack_valid <= 1'b0;
      ack_ok    <= 1'b0;
      tx_valid  <= 1'b0;
      if (rst) begin
        mptr     <= '0;
        pptr     <= '0;
        dblk     <= '0;
        spc      <= 1'b0;
        tx_sel   <= 1'b0;
        cm_space <= 1'b0;
        cm_base  <= '0;
      end
    end else begin
      ack_valid <= rx_valid;
      ack_ok    <= 1'b0;
      tx_valid  <= rd_go;
      if (rd_go) begin
        tx_sel <= spc;
        if (!spc) mptr <= {mptr[ADDR_W-1:BLK_W], mptr[BLK_W-1:0] + 1'b1};
      end
      if (start_evt) begin
        st    <= S_DEV;
        cnt   <= '0;
        abort <= 1'b0;
      end else if (stop_evt) begin
        st    <= S_IDLE;
        cnt   <= '0;
        abort <= 1'b0;
      end else if (rx_valid) begin
        unique case (st)
          S_DEV: begin
            if (busy || !(hit_main || hit_prot)) st <= S_IGN;
            else if (!rx_byte[0]) begin
              spc <= hit_prot;
              if (hit_main) dblk <= rx_byte[DEV_BLK_W:1];
              ack_ok <= 1'b1;
              st     <= S_WADDR;
            end else if (perm_ok) begin
              spc    <= hit_prot;
              ack_ok <= 1'b1;
              st     <= S_RDATA;
            end else st <= S_IGN;
          end
          S_WADDR: begin
            if (spc && (rx_byte[7:PSP_W] != '0)) st <= S_IGN;
            else begin
              if (spc) pptr <= rx_byte[PSP_W-1:0];
              else     mptr <= {dblk, rx_byte};
              ack_ok <= 1'b1;
              st     <= S_WDATA;
            end
          end
          S_WDATA: begin
            if (byte_take) begin
              ack_ok <= 1'b1;
              cnt    <= cnt + 1'b1;
              if (cnt == '0) begin
                cm_space <= spc;
                cm_base  <= spc ? PG_IDX_W'(pptr[PSP_W-1:PAGE_W])
                                : mptr[ADDR_W-1:PAGE_W];
              end
              if (!spc) mptr <= {mptr[ADDR_W-1:PAGE_W], mptr[PAGE_W-1:0] + 1'b1};
            end else abort <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  seq_wlatch #(.IDX_W(PAGE_W), .DW(8)) u_latch (
    .clk(clk), .rst(rst), .clr(clr), .we(take), .widx(widx), .wdata(rx_byte),
    .ridx(cidx), .rdata(ldata), .rvalid(lvalid)
  );

  seq_wtimer #(.CYC(WR_CYCLES), .IDX_W(PAGE_W)) u_timer (
    .clk(clk), .rst(rst), .go(go), .busy(busy), .cen(cen), .cidx(cidx), .done(done)
  );

  seq_ram #(.AW(ADDR_W), .DW(8)) u_main (
    .clk(clk), .we(cen && lvalid && !cm_space), .waddr({cm_base, cidx}),
    .wdata(ldata), .re(rd_go), .raddr(mptr), .rdata(mq)
  );

  seq_ram #(.AW(PSP_W), .DW(8)) u_prot (
    .clk(clk), .we(cen && lvalid && cm_space), .waddr({cm_base[PHI_W-1:0], cidx}),
    .wdata(ldata), .re(rd_go), .raddr(pptr), .rdata(pq)
  );

  assign tx_byte = tx_sel ? pq : mq;

  // R4: silent for the whole write cycle
  assert_busy_silent_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && rx_valid && prot_n) |=> (ack_valid && !ack_ok));
  // R3: never more than one page of bytes collected
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIM_MAIN);
  // R11: protect reset forces idle and silence
  assert_prot_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !prot_n |=> (st == S_IDLE && !ack_valid));
  // R5: a read byte follows each request by one cycle
  assert_tx_lat_R5: assert property (@(posedge clk) disable iff (rst)
    (tx_req && prot_n && st == S_RDATA) |=> tx_valid);
  // R10: a denied access is never acknowledged
  assert_perm_nack_R10: assert property (@(posedge clk) disable iff (rst)
    (perm_req && !perm_ok) |=> !ack_ok);
endmodule

// File: tb/tb_eeprom_i2c_seq.sv
module tb_eeprom_i2c_seq;
  localparam int CYC = 40;

  logic clk = 1'b0;
  logic rst = 1'b1, prot_n = 1'b1, wp = 1'b0;
  logic start_evt = 1'b0, stop_evt = 1'b0, rx_valid = 1'b0, tx_req = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic ack_valid, ack_ok, tx_valid, perm_req, perm_write, perm_space, perm_ok, busy;
  logic [7:0] tx_byte;
  logic [9:0] perm_addr;
  logic deny_en = 1'b0;
  logic [7:0] shadow [1024];
  logic [7:0] pshadow [32];
  int total = 0, fails = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  // external permission checker model: deny writes to block 6, reads of block 4
  always_comb begin
    perm_ok = 1'b1;
    if (deny_en && perm_req && !perm_space) begin
      if (perm_write && perm_addr[9:7] == 3'd6) perm_ok = 1'b0;
      if (!perm_write && perm_addr[9:7] == 3'd4) perm_ok = 1'b0;
    end
  end

  eeprom_i2c_seq #(.WR_CYCLES(CYC)) dut (
    .clk(clk), .rst(rst), .prot_n(prot_n), .wp(wp), .start_evt(start_evt),
    .stop_evt(stop_evt), .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_req(tx_req),
    .ack_valid(ack_valid), .ack_ok(ack_ok), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .perm_req(perm_req), .perm_write(perm_write), .perm_space(perm_space),
    .perm_addr(perm_addr), .perm_ok(perm_ok), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a, input int salt);
    return 8'((a * 13 + salt * 29 + (a >> 8)) & 8'hFF);
  endfunction

  task automatic ev_start();
    start_evt = 1'b1; @(negedge clk); start_evt = 1'b0;
  endtask
  task automatic ev_stop();
    stop_evt = 1'b1; @(negedge clk); stop_evt = 1'b0;
  endtask
  task automatic put(input logic [7:0] b, input bit exp, input string tag);
    rx_byte = b; rx_valid = 1'b1; @(negedge clk); rx_valid = 1'b0;
    chk(ack_valid && ack_ok == exp, tag, {30'd0, ack_valid, ack_ok}, {30'd0, 1'b1, exp});
  endtask
  task automatic get(input logic [7:0] exp, input string tag);
    tx_req = 1'b1; @(negedge clk); tx_req = 1'b0;
    chk(tx_valid && tx_byte == exp, tag, {23'd0, tx_valid, tx_byte}, {23'd0, 1'b1, exp});
  endtask
  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask
  // set main pointer with a write command, then read n bytes through a repeated START
  task automatic set_and_read(input logic [9:0] a, input int n, input logic [1:0] rdblk,
                              input string tag);
    ev_start();
    put(8'hA8 | {5'd0, a[9:8], 1'b0}, 1'b1, tag);
    put(a[7:0], 1'b1, tag);
    ev_start();
    put(8'hA9 | {5'd0, rdblk, 1'b0}, 1'b1, tag);
    for (int i = 0; i < n; i++)
      get(shadow[{a[9:7], 7'(a[6:0] + i)}], tag);
    ev_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      fails++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(!busy && !ack_valid && !tx_valid && !perm_req, "R12 reset",
        {28'd0, busy, ack_valid, tx_valid, perm_req}, 0);

    // R1 foreign device codes are refused and the rest of the transfer ignored
    ev_start(); put(8'hA0, 1'b0, "R1 bad dev A0"); put(8'h00, 1'b0, "R1 ignored byte"); ev_stop();
    ev_start(); put(8'hB0, 1'b0, "R1 bad dev B0"); ev_stop();

    // R2 R4 fill every page with a full page write
    for (int p = 0; p < 64; p++) begin
      ev_start();
      put(8'hA8 | {5'd0, 2'(p >> 4), 1'b0}, 1'b1, "R1 main dev");
      put({4'(p), 4'h0}, 1'b1, "R2 word addr");
      for (int i = 0; i < 16; i++) begin
        put(pat(p * 16 + i, 1), 1'b1, "R2 page data");
        shadow[p * 16 + i] = pat(p * 16 + i, 1);
      end
      if (p == 0) chk(!busy, "R4 no busy before STOP", {31'd0, busy}, 0);
      ev_stop();
      if (p == 0) begin
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        chk(n == CYC, "R4 busy window", n, CYC);
      end else wait_idle();
    end

    // R5 R6 read each block past its end; block bits of the read command inverted
    for (int b = 0; b < 8; b++)
      set_and_read(10'(b * 128), 130, ~2'(b >> 1), "R5 R6 block read");

    // R2 page wrap: start at byte 12 of page 5
    ev_start(); put(8'hA8, 1'b1, "R2 dev"); put(8'h5C, 1'b1, "R2 word");
    for (int i = 0; i < 6; i++) begin
      put(pat(i, 7), 1'b1, "R2 wrap data");
      shadow[{6'd5, 4'(12 + i)}] = pat(i, 7);
    end
    ev_stop(); wait_idle();
    set_and_read(10'h050, 16, 2'd0, "R2 wrap readback");

    // R3 a 17th byte is refused and nothing is programmed
    ev_start(); put(8'hA8, 1'b1, "R3 dev"); put(8'h90, 1'b1, "R3 word");
    for (int i = 0; i < 16; i++) put(8'h5A, 1'b1, "R3 data");
    put(8'h5A, 1'b0, "R3 17th byte");
    put(8'h5A, 1'b0, "R3 18th byte");
    ev_stop();
    chk(!busy, "R3 no write cycle", {31'd0, busy}, 0);
    set_and_read(10'h090, 16, 2'd0, "R3 page unchanged");

    // R4 address refused while the write cycle runs
    ev_start(); put(8'hAE, 1'b1, "R4 dev"); put(8'hA0, 1'b1, "R4 word");
    put(8'hC3, 1'b1, "R4 data"); shadow[10'h3A0] = 8'hC3;
    ev_stop();
    chk(busy, "R4 busy after STOP", {31'd0, busy}, 1);
    ev_start(); put(8'hA8, 1'b0, "R4 busy NACK"); ev_stop();
    wait_idle();
    set_and_read(10'h3A0, 2, 2'd3, "R4 readback");

    // R7 write protect: pointer set, data refused
    wp = 1'b1;
    ev_start(); put(8'hAC, 1'b1, "R7 dev"); put(8'h10, 1'b1, "R7 word");
    put(8'hEE, 1'b0, "R7 data NACK"); ev_stop();
    chk(!busy, "R7 no write cycle", {31'd0, busy}, 0);
    wp = 1'b0;
    ev_start(); put(8'hA9, 1'b1, "R7 current read");
    get(shadow[10'h210], "R7 pointer kept, data unchanged"); ev_stop();

    // R8 protection/ID space
    ev_start(); put(8'hB8, 1'b1, "R8 dev"); put(8'h05, 1'b1, "R8 word");
    put(8'h3C, 1'b1, "R8 data"); ev_stop(); wait_idle();
    ev_start(); put(8'hB8, 1'b1, "R8 dev"); put(8'h05, 1'b1, "R8 word");
    ev_start(); put(8'hB9, 1'b1, "R8 read dev"); get(8'h3C, "R8 readback"); ev_stop();
    ev_start(); put(8'hB8, 1'b1, "R8 dev"); put(8'h25, 1'b0, "R8 out-of-range word"); ev_stop();

    // R9 single byte only
    ev_start(); put(8'hB8, 1'b1, "R9 dev"); put(8'h06, 1'b1, "R9 word");
    put(8'h5A, 1'b1, "R9 first"); ev_stop(); wait_idle();
    ev_start(); put(8'hB8, 1'b1, "R9 dev"); put(8'h06, 1'b1, "R9 word");
    put(8'hA5, 1'b1, "R9 one byte"); put(8'h77, 1'b0, "R9 second byte NACK"); ev_stop();
    chk(!busy, "R9 no write cycle", {31'd0, busy}, 0);
    ev_start(); put(8'hB8, 1'b1, "R9 dev"); put(8'h06, 1'b1, "R9 word");
    ev_start(); put(8'hB9, 1'b1, "R9 read"); get(8'h5A, "R9 unchanged"); ev_stop();

    // R10 external permission
    deny_en = 1'b1;
    ev_start(); put(8'hAE, 1'b1, "R10 dev"); put(8'h00, 1'b1, "R10 word");
    put(8'h11, 1'b0, "R10 denied write"); ev_stop();
    chk(!busy, "R10 no write cycle", {31'd0, busy}, 0);
    set_and_read(10'h300, 4, 2'd3, "R10 block 6 unchanged");
    ev_start(); put(8'hAC, 1'b1, "R10 dev"); put(8'h00, 1'b1, "R10 word");
    ev_start(); put(8'hA9, 1'b0, "R10 denied read"); ev_stop();
    deny_en = 1'b0;

    // R11 protect reset mid-write
    ev_start(); put(8'hA8, 1'b1, "R11 dev"); put(8'h70, 1'b1, "R11 word");
    for (int i = 0; i < 3; i++) put(8'h99, 1'b1, "R11 data");
    prot_n = 1'b0; @(negedge clk);
    rx_byte = 8'h99; rx_valid = 1'b1; @(negedge clk); rx_valid = 1'b0;
    chk(!ack_valid, "R11 silent while low", {31'd0, ack_valid}, 0);
    prot_n = 1'b1; @(negedge clk);
    ev_stop();
    chk(!busy, "R11 latch discarded", {31'd0, busy}, 0);
    set_and_read(10'h070, 4, 2'd0, "R11 page unchanged");

    done_flag = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule